// File: doc/BRIEF.md
# Memory Exerciser Front-End Sequencer

This block sits between a small operator panel (four push buttons, a 3-bit switch field, eight LEDs and one status LED) and the user-side port of a DDR2-style memory controller. After reset it stays silent until the controller reports that its initialization has finished. It then runs a self-test: it writes one 64-bit word to each of the 16 addresses, using a pattern derived from the address, and reads back the word at address 0 into a display register.

After the self-test the block becomes a single-word monitor. Two buttons move a 4-bit address pointer up and down. A third button reads the word at the pointer into the display register. A fourth button writes a fixed constant to the pointer. The switch field picks which byte of the display register is shown on the LEDs. Every 64-bit word crosses the controller port as four 16-bit beats.

The command port and the write-beat port are valid/ready streams. Once the block raises a valid, it holds that valid and its payload unchanged until the controller raises ready in the same cycle. The read-beat port is a valid/ready stream in the other direction. The block raises its ready only while it is collecting the beats of a read it has issued, and the controller may hold back beats by keeping its valid low. The reset switch, the init flag, the buttons, the switches and the LEDs are plain pins.

Top module: `mem_exerciser_seq`

## Requirements
- R1: While `init_done` has not been seen high since the last reset, `cmd_valid` and `wr_valid` stay low.
- R2: Once initialization has been seen, the block issues 16 write commands to addresses 0, 1, … 15 in that order. Beat b of the word for address a is 0xA500 | (a << 4) | b.
- R3: After the 16th write has sent all of its beats, the block issues one read of address 0 and loads the returned word into the display register.
- R4: A 64-bit word moves as exactly four 16-bit beats. Beat 0 carries bits 15:0 and beat 3 carries bits 63:48, in the same order for writes and reads.
- R5: `cmd_valid` with `cmd_addr`/`cmd_write`, and `wr_valid` with `wr_data`, stay stable while ready is low. Write beats appear only after their command has been accepted, and the next command waits until all four beats have been accepted.
- R6: `rd_ready` is high only between the acceptance of a read command and the acceptance of that read's fourth beat. A beat transfers on a cycle where both `rd_valid` and `rd_ready` are high.
- R7: `rst_sw` high at a clock edge returns the block to the state after power-up: pointer 0, display register 0, waiting for initialization, with the self-test repeated afterwards.
- R8: `led` equals bits 8·`byte_sel`+7 down to 8·`byte_sel` of the display register.
- R9: The up button adds one to the pointer and the down button subtracts one, both modulo 16.
- R10: The read button reads the word at the pointer and replaces the display register with it. The display register changes at no other time.
- R11: The write button writes the constant 0x0123_4567_89AB_CDEF to the pointer.
- R12: Each rising edge of a synchronized button causes at most one action. Edges that arrive during the self-test or during an access are dropped. When several edges arrive in the same cycle, only one action is taken, in the priority read, then write, then up, then down.
- R13: `hb_led` is the top bit of a free-running counter of HB_BITS bits, so it toggles every 2^(HB_BITS-1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_sw | input | 1 | Synchronous reset switch, active high |
| init_done | input | 1 | Controller reports initialization finished |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Controller accepts command |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | ADDR_W | Word address of the command |
| wr_valid | output | 1 | Write beat offered |
| wr_ready | input | 1 | Controller accepts write beat |
| wr_data | output | BEAT_W | Write beat |
| rd_valid | input | 1 | Read beat offered by controller |
| rd_ready | output | 1 | Block accepts read beat |
| rd_data | input | BEAT_W | Read beat |
| btn_up | input | 1 | Pointer increment button |
| btn_down | input | 1 | Pointer decrement button |
| btn_read | input | 1 | Single-word read button |
| btn_write | input | 1 | Single-word write button |
| byte_sel | input | SEL_W | Byte select switches |
| led | output | 8 | Selected byte of display register |
| hb_led | output | 1 | Heartbeat LED |

## Verification
The bench models the controller with ready and valid patterns that stall at irregular points. A design that dropped or repeated a beat under back-pressure, or changed the payload during a stall, would produce a word that does not match the scoreboard.

The pointer is taken through its wrap in both directions. One button is held for many cycles to test edge detection. Presses are made while a read is stalled, and two buttons are pressed in the same cycle. A design without edge detection, or one that acted on presses while busy, or one with the wrong priority, would issue a command to an unexpected address or issue an extra command.

A reset in the middle of operation must clear the display and repeat the self-test. The displayed bytes are swept across all eight selections to catch a reversed beat or byte order.

// File: rtl/mes_pkg.sv
package mes_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_INIT,
    ST_WR_CMD,
    ST_WR_BEATS,
    ST_RD_CMD,
    ST_RD_BEATS,
    ST_IDLE
  } seq_state_e;

  localparam int NUM_BTN = 4;
  localparam int BTN_UP    = 0;
  localparam int BTN_DOWN  = 1;
  localparam int BTN_READ  = 2;
  localparam int BTN_WRITE = 3;
endpackage

// File: rtl/mes_btn_sync.sv
module mes_btn_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] pulse_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign pulse_o = sync_q & ~prev_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst) ((pulse_o & $past(pulse_o)) == '0)); // R12
endmodule

// File: rtl/mes_beat_tx.sv
module mes_beat_tx #(
  parameter int BEAT_W = 16,
  parameter int BEATS  = 4,
  localparam int WORD_W = BEAT_W * BEATS,
  localparam int IDX_W  = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [BEAT_W-1:0] data_o,
  output logic              done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);

  logic [WORD_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic              act_q;

  assign valid_o = act_q;
  assign data_o  = sh_q[BEAT_W-1:0];
  assign done_o  = act_q && ready_i && (idx_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      idx_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= word_i;
      idx_q <= '0;
      act_q <= 1'b1;
    end else if (act_q && ready_i) begin
      sh_q <= sh_q >> BEAT_W;
      if (idx_q == LAST) begin
        idx_q <= '0;
        act_q <= 1'b0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst) (valid_o && !ready_i) |=> (valid_o && $stable(data_o))); // R5
  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (rst) load_i |-> !act_q); // R5
endmodule

// File: rtl/mes_beat_rx.sv
module mes_beat_rx #(
  parameter int BEAT_W = 16,
  parameter int BEATS  = 4,
  localparam int WORD_W = BEAT_W * BEATS,
  localparam int IDX_W  = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic              valid_i,
  input  logic [BEAT_W-1:0] data_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);

  logic [WORD_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;

  assign word_o = {data_i, sh_q[WORD_W-1:BEAT_W]};
  assign done_o = take_i && valid_i && (idx_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (take_i && valid_i) begin
      sh_q  <= word_o;
      idx_q <= (idx_q == LAST) ? '0 : idx_q + IDX_W'(1);
    end
  end

  AST_RX_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst) !take_i |-> (idx_q == '0)); // R6
endmodule

// File: rtl/mes_heartbeat.sv
module mes_heartbeat #(
  parameter int HB_BITS = 24
) (
  input  logic clk,
  input  logic rst,
  output logic led_o
);
  logic [HB_BITS-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + HB_BITS'(1);
  end

  assign led_o = cnt_q[HB_BITS-1];
endmodule

// File: rtl/mem_exerciser_seq.sv
module mem_exerciser_seq
  import mes_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int BEAT_W  = 16,
  parameter int BEATS   = 4,
  parameter int HB_BITS = 24,
  parameter logic [BEAT_W*BEATS-1:0] FIXED_WORD = 64'h0123_4567_89AB_CDEF,
  localparam int WORD_W = BEAT_W * BEATS,
  localparam int SEL_W  = $clog2(WORD_W / 8)
) (
  input  logic              clk,
  input  logic              rst_sw,
  input  logic              init_done,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [BEAT_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [BEAT_W-1:0] rd_data,
  input  logic              btn_up,
  input  logic              btn_down,
  input  logic              btn_read,
  input  logic              btn_write,
  input  logic [SEL_W-1:0]  byte_sel,
  output logic [7:0]        led,
  output logic              hb_led
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  seq_state_e          state_q, state_d;
  logic                selftest_q;
  logic                init_seen_q;
  logic [ADDR_W-1:0]   auto_addr_q;
  logic [ADDR_W-1:0]   ptr_q;
  logic [WORD_W-1:0]   shown_q;
  logic [NUM_BTN-1:0]  btn_raw, btn_pulse;
  logic                tx_load, tx_done, rx_done;
  logic [WORD_W-1:0]   tx_word, rx_word;

  function automatic logic [WORD_W-1:0] auto_word(input logic [ADDR_W-1:0] a);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int b = 0; b < BEATS; b++) begin
      w[b*BEAT_W +: BEAT_W] = BEAT_W'(32'hA500 | (32'(a) << 4) | 32'(b));
    end
    return w;
  endfunction

  assign btn_raw[BTN_UP]    = btn_up;
  assign btn_raw[BTN_DOWN]  = btn_down;
  assign btn_raw[BTN_READ]  = btn_read;
  assign btn_raw[BTN_WRITE] = btn_write;

  mes_btn_sync #(.N(NUM_BTN)) u_btn (
    .clk     (clk),
    .rst     (rst_sw),
    .raw_i   (btn_raw),
    .pulse_o (btn_pulse)
  );

  mes_beat_tx #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_tx (
    .clk     (clk),
    .rst     (rst_sw),
    .load_i  (tx_load),
    .word_i  (tx_word),
    .valid_o (wr_valid),
    .ready_i (wr_ready),
    .data_o  (wr_data),
    .done_o  (tx_done)
  );

  mes_beat_rx #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_rx (
    .clk     (clk),
    .rst     (rst_sw),
    .take_i  (rd_ready),
    .valid_i (rd_valid),
    .data_i  (rd_data),
    .done_o  (rx_done),
    .word_o  (rx_word)
  );

  mes_heartbeat #(.HB_BITS(HB_BITS)) u_hb (
    .clk   (clk),
    .rst   (rst_sw),
    .led_o (hb_led)
  );

  always_comb begin
    state_d   = state_q;
    cmd_valid = 1'b0;
    cmd_write = 1'b0;
    cmd_addr  = ptr_q;
    rd_ready  = 1'b0;
    tx_load   = 1'b0;
    tx_word   = selftest_q ? auto_word(auto_addr_q) : FIXED_WORD;
    case (state_q)
      ST_WAIT_INIT: begin
        if (init_done) state_d = ST_WR_CMD;
      end
      ST_WR_CMD: begin
        cmd_valid = 1'b1;
        cmd_write = 1'b1;
        cmd_addr  = selftest_q ? auto_addr_q : ptr_q;
        if (cmd_ready) begin
          tx_load = 1'b1;
          state_d = ST_WR_BEATS;
        end
      end
      ST_WR_BEATS: begin
        if (tx_done) begin
          if (!selftest_q)                    state_d = ST_IDLE;
          else if (auto_addr_q == LAST_ADDR)  state_d = ST_RD_CMD;
          else                                state_d = ST_WR_CMD;
        end
      end
      ST_RD_CMD: begin
        cmd_valid = 1'b1;
        cmd_addr  = selftest_q ? '0 : ptr_q;
        if (cmd_ready) state_d = ST_RD_BEATS;
      end
      ST_RD_BEATS: begin
        rd_ready = 1'b1;
        if (rx_done) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (btn_pulse[BTN_READ])       state_d = ST_RD_CMD;
        else if (btn_pulse[BTN_WRITE]) state_d = ST_WR_CMD;
      end
      default: state_d = ST_WAIT_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_sw) begin
      state_q     <= ST_WAIT_INIT;
      selftest_q  <= 1'b1;
      init_seen_q <= 1'b0;
      auto_addr_q <= '0;
      ptr_q       <= '0;
      shown_q     <= '0;
    end else begin
      state_q <= state_d;
      if (init_done) init_seen_q <= 1'b1;
      if (state_q == ST_WR_BEATS && tx_done && selftest_q)
        auto_addr_q <= auto_addr_q + ADDR_W'(1);
      if (rx_done) begin
        shown_q    <= rx_word;
        selftest_q <= 1'b0;
      end
      if (state_q == ST_IDLE && !btn_pulse[BTN_READ] && !btn_pulse[BTN_WRITE]) begin
        if (btn_pulse[BTN_UP])        ptr_q <= ptr_q + ADDR_W'(1);
        else if (btn_pulse[BTN_DOWN]) ptr_q <= ptr_q - ADDR_W'(1);
      end
    end
  end

  assign led = shown_q[{byte_sel, 3'b000} +: 8];

  AST_NO_EARLY_CMD: assert property (@(posedge clk) disable iff (rst_sw) (cmd_valid || wr_valid) |-> init_seen_q); // R1
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst_sw) (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_write))); // R5
  AST_BEATS_AFTER_CMD: assert property (@(posedge clk) disable iff (rst_sw) wr_valid |-> (state_q == ST_WR_BEATS)); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst_sw) (ptr_q != $past(ptr_q)) |-> ((ADDR_W'(ptr_q - $past(ptr_q)) == ADDR_W'(1)) || (ADDR_W'($past(ptr_q) - ptr_q) == ADDR_W'(1)))); // R9
  AST_PTR_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst_sw) (state_q != ST_IDLE) |=> (ptr_q == $past(ptr_q))); // R12
  AST_SHOWN_ONLY_READ: assert property (@(posedge clk) disable iff (rst_sw) (shown_q != $past(shown_q)) |-> $past(rx_done)); // R10
endmodule

// File: tb/mem_exerciser_seq_tb.sv
module mem_exerciser_seq_tb;
  localparam logic [63:0] FIXED = 64'h0123_4567_89AB_CDEF;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_sw, init_done, cmd_ready, wr_ready, rd_valid;
  logic [15:0] rd_data;
  logic        btn_up, btn_down, btn_read, btn_write;
  logic [2:0]  byte_sel;
  logic        cmd_valid, cmd_write, wr_valid, rd_ready, hb_led;
  logic [3:0]  cmd_addr;
  logic [15:0] wr_data;
  logic [7:0]  led;

  mem_exerciser_seq #(.HB_BITS(4)) u_dut (
    .clk(clk), .rst_sw(rst_sw), .init_done(init_done),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .btn_up(btn_up), .btn_down(btn_down), .btn_read(btn_read), .btn_write(btn_write),
    .byte_sel(byte_sel), .led(led), .hb_led(hb_led)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pattern_word(input logic [3:0] a);
    logic [63:0] w;
    for (int b = 0; b < 4; b++) w[16*b +: 16] = 16'hA500 | (16'(a) << 4) | 16'(b);
    return w;
  endfunction

  // scoreboard state
  logic [63:0] mem [16];
  logic [3:0]  exp_wr_addr [$];
  logic [63:0] exp_wr_word [$];
  string       exp_wr_tag  [$];
  logic [3:0]  exp_rd_addr [$];
  bit          stall_rd = 1'b0;
  int          cyc = 0;
  int          early_cmds = 0;
  bit          wr_open, rd_open, prev_cmd_stall, prev_wr_stall;
  logic [3:0]  wr_addr_cur, prev_addr;
  logic        prev_write;
  logic [15:0] prev_wdata;
  logic [63:0] wr_acc, rd_src;
  int          wr_beats, rd_beats;
  logic [3:0]  bptr;

  // controller model and monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_sw) begin
      cmd_ready = 1'b0; wr_ready = 1'b0; rd_valid = 1'b0; rd_data = '0;
      wr_open = 0; rd_open = 0; prev_cmd_stall = 0; prev_wr_stall = 0;
      wr_beats = 0; rd_beats = 0;
    end else begin
      if (prev_cmd_stall)
        chk(cmd_valid && cmd_addr == prev_addr && cmd_write == prev_write, "R5 command held under stall", {59'd0, cmd_valid, cmd_addr}, {59'd1, prev_addr});
      if (prev_wr_stall)
        chk(wr_valid && wr_data == prev_wdata, "R5 beat held under stall", {47'd0, wr_valid, wr_data}, {47'd1, prev_wdata});
      if (!init_done && (cmd_valid || wr_valid)) early_cmds++;
      if (wr_valid && !wr_open) chk(0, "R5 write beat without accepted command", 64'd1, 64'd0);
      if (rd_ready != rd_open) chk(0, "R6 rd_ready outside read window", {63'd0, rd_ready}, {63'd0, rd_open});

      cmd_ready = (cyc % 3) != 0;
      wr_ready  = (cyc % 4) != 1;
      rd_valid  = rd_open && !stall_rd && ((cyc % 5) != 2);
      rd_data   = rd_open ? rd_src[16*rd_beats +: 16] : 16'h0;

      prev_cmd_stall = cmd_valid && !cmd_ready;
      prev_addr = cmd_addr; prev_write = cmd_write;
      prev_wr_stall = wr_valid && !wr_ready;
      prev_wdata = wr_data;

      if (wr_valid && wr_ready && wr_open) begin
        wr_acc[16*wr_beats +: 16] = wr_data;
        wr_beats++;
        if (wr_beats == 4) begin
          wr_open = 0;
          mem[wr_addr_cur] = wr_acc;
          if (exp_wr_addr.size() == 0) chk(0, "R12 unexpected write", {60'd0, wr_addr_cur}, 64'd0);
          else begin
            string t;
            logic [3:0] ea;
            logic [63:0] ew;
            t = exp_wr_tag.pop_front(); ea = exp_wr_addr.pop_front(); ew = exp_wr_word.pop_front();
            chk(wr_addr_cur == ea, {t, " write address"}, {60'd0, wr_addr_cur}, {60'd0, ea});
            chk(wr_acc == ew, {t, " R4 write word"}, wr_acc, ew);
          end
        end
      end
      if (rd_valid && rd_ready && rd_open) begin
        rd_beats++;
        if (rd_beats == 4) rd_open = 0;
      end
      if (cmd_valid && cmd_ready) begin
        if (cmd_write) begin
          wr_open = 1; wr_beats = 0; wr_addr_cur = cmd_addr;
        end else begin
          if (exp_rd_addr.size() == 0) chk(0, "R12 unexpected read", {60'd0, cmd_addr}, 64'd0);
          else begin
            logic [3:0] ra;
            ra = exp_rd_addr.pop_front();
            chk(cmd_addr == ra, "R10 read address", {60'd0, cmd_addr}, {60'd0, ra});
          end
          rd_open = 1; rd_beats = 0; rd_src = mem[cmd_addr];
        end
      end
    end
  end

  task automatic wait_quiet();
    while (exp_wr_addr.size() != 0 || exp_rd_addr.size() != 0 || wr_open || rd_open) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic press(input bit u, input bit d, input bit r, input bit w, input int hold);
    @(negedge clk);
    btn_up = u; btn_down = d; btn_read = r; btn_write = w;
    repeat (hold) @(negedge clk);
    btn_up = 0; btn_down = 0; btn_read = 0; btn_write = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_leds(input logic [63:0] exp, input string req);
    for (int s = 0; s < 8; s++) begin
      byte_sel = 3'(s);
      @(negedge clk);
      chk(led == exp[8*s +: 8], {req, " R8 byte select"}, {56'd0, led}, {56'd0, exp[8*s +: 8]});
    end
    byte_sel = 3'd0;
  endtask

  task automatic push_selftest();
    for (int a = 0; a < 16; a++) begin
      exp_wr_addr.push_back(4'(a)); exp_wr_word.push_back(pattern_word(4'(a))); exp_wr_tag.push_back("R2");
    end
    exp_rd_addr.push_back(4'd0);
  endtask

  task automatic do_write();
    exp_wr_addr.push_back(bptr); exp_wr_word.push_back(FIXED); exp_wr_tag.push_back("R11");
    press(0, 0, 0, 1, 2);
    wait_quiet();
  endtask

  task automatic do_read(input string req);
    exp_rd_addr.push_back(bptr);
    press(0, 0, 1, 0, 2);
    wait_quiet();
    check_leds(mem[bptr], req);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    int last_t, gaps_bad, toggles;
    logic prev_hb;
    rst_sw = 1; init_done = 0; byte_sel = 0;
    btn_up = 0; btn_down = 0; btn_read = 0; btn_write = 0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    bptr = 0;
    repeat (5) @(negedge clk);
    rst_sw = 0;
    @(negedge clk);
    chk(led == 8'h00 && !cmd_valid && !wr_valid && !rd_ready, "R7 reset state", {cmd_valid, wr_valid, rd_ready, led}, 64'd0);

    // R13: heartbeat toggles every 8 cycles with HB_BITS=4; R12: press ignored before self-test
    prev_hb = hb_led; last_t = -1; gaps_bad = 0; toggles = 0;
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      if (t == 10) btn_up = 1;
      if (t == 14) btn_up = 0;
      if (hb_led != prev_hb) begin
        if (last_t >= 0 && (t - last_t) != 8) gaps_bad++;
        last_t = t; toggles++;
      end
      prev_hb = hb_led;
    end
    chk(gaps_bad == 0 && toggles >= 6, "R13 heartbeat period", 64'(gaps_bad), 64'd0);
    chk(early_cmds == 0, "R1 no command before init", 64'(early_cmds), 64'd0);

    // self-test
    push_selftest();
    init_done = 1;
    repeat (30) @(negedge clk);
    press(1, 0, 0, 0, 3);
    wait_quiet();
    chk({led} == 8'h00, "R3 R4 low byte of word 0", {56'd0, led}, 64'd0);
    check_leds(64'hA503_A502_A501_A500, "R3 R4");

    // pointer still 0: write there, then read it back
    do_write();
    do_read("R10");
    // wrap downwards
    press(0, 1, 0, 0, 2); bptr = 4'd15;
    do_write();
    do_read("R9");
    // wrap upwards and step
    press(1, 0, 0, 0, 2); press(1, 0, 0, 0, 2); bptr = 4'd1;
    do_read("R9 R10");
    // long hold gives one step
    press(1, 0, 0, 0, 25); bptr = 4'd2;
    do_read("R12 held button");

    // press while a read is stalled is dropped
    stall_rd = 1;
    exp_rd_addr.push_back(bptr);
    press(0, 0, 1, 0, 2);
    press(1, 0, 0, 0, 2);
    press(0, 0, 0, 1, 2);
    stall_rd = 0;
    wait_quiet();
    check_leds(mem[bptr], "R12 busy read");
    do_write();
    chk(mem[2] == FIXED, "R12 pointer unchanged by busy press", mem[2], FIXED);

    // simultaneous read and write: read wins
    bptr = 4'd2;
    mem[2] = mem[2];
    exp_rd_addr.push_back(bptr);
    press(0, 0, 1, 1, 2);
    wait_quiet();
    check_leds(FIXED, "R12 priority");
    // simultaneous up and down: up wins
    press(1, 1, 0, 0, 2); bptr = 4'd3;
    do_read("R12 up over down");

    // reset in operation
    rst_sw = 1; init_done = 0;
    repeat (3) @(negedge clk);
    rst_sw = 0;
    @(negedge clk);
    chk(led == 8'h00, "R7 display cleared", {56'd0, led}, 64'd0);
    early_cmds = 0;
    repeat (20) @(negedge clk);
    chk(early_cmds == 0, "R7 R1 waits for init again", 64'(early_cmds), 64'd0);
    push_selftest();
    init_done = 1;
    wait_quiet();
    check_leds(pattern_word(4'd0), "R7 self-test repeated");
    bptr = 4'd0;
    do_write();
    chk(mem[0] == FIXED, "R7 pointer back at 0", mem[0], FIXED);

    finish_run();
  end
endmodule